// File: doc/BRIEF.md
# Smart Card Character Transmitter

This block drains a small byte queue onto the single open-drain I/O line of an ISO 7816 card. Every byte goes out as one asynchronous character. The bit time (elementary time unit, ETU) is set in clock cycles by an input. Character framing follows T=0 or T=1, chosen by a mode input. In T=0 the block listens for the card's error signal during the guard time and sends a rejected character once more. In T=1 it can close a message with a one-byte LRC or a CRC-16.

Firmware drives a direction bit and a last-byte marker, and reads a set of status flags. Two flags describe the queue: full and empty. Two are error flags, underrun and break, and both clear on a read strobe. The empty flag and the end of the message are linked. While the last-byte marker is set, the empty flag stays low until the final data character and any checksum are fully on the line. Receive direction can also be requested early, and the hardware then takes it once nothing is left to send. Single-cycle pulses report transmit events and transmit errors.

Top module: `sc_tx_ctrl`

## Requirements
- R1: After reset the line is released (io_drv_low=0), tx_empty=1, tx_full=0, dir_tx=0, last_flag=0, tx_underrun=0 and tx_break=0.
- R2: tx_full is 1 exactly while the queue holds FIFO_DEPTH (default 4) bytes. Its rising edge produces one evt_irq pulse.
- R3: Each character drives, in this order: a start bit of 0, the 8 data bits LSB first, and a parity bit that makes the nine bits after the start bit even. io_drv_low=1 pulls the line low. The line is then released for a guard time of 2 ETU.
- R4: Every bit lasts etu_div clock cycles (etu_div of at least 4). Bytes are sent in the order they were written.
- R5: tx_empty reads 1 when the queue is empty. While last_flag=1 it stays 0 until the final character (and any checksum) has completed. Its rising edge produces one evt_irq pulse.
- R6: Suppose a data character completes with the queue empty and last_flag=0. Then tx_underrun sets and err_irq pulses. The flag holds until stat_rd, which clears it. With last_flag=1 there is no underrun.
- R7: The line is sampled 10.5 ETU after the start edge, and a low level there counts as a card error. tx_break then sets (cleared by stat_rd) and err_irq pulses. In T=0 (t1_mode=0) the rejected character is sent again exactly once, before the next queued byte.
- R8: In T=1 (t1_mode=1) with chk_en=1, crc_sel=0 and last_flag=1, one LRC byte (the XOR of the message's data bytes) follows the last data byte. tx_empty stays 0 until it has been sent.
- R9: With crc_sel=1 the appended checksum is a CRC-16. It uses polynomial 0x1021 and initial value 0xFFFF, bytes enter MSB first, and it is sent high byte first.
- R10: ctl_wr loads dir_tx from ctl_dir (1 = transmit) and last_flag from ctl_last. With dir_tx=0 no new character starts, so written bytes stay queued. Writing ctl_dir=0 with ctl_last=0 takes effect on the next cycle.
- R11: Writing ctl_dir=0 with ctl_last=1 while data remains keeps dir_tx=1 until everything has been sent. dir_tx then falls without further writes.
- R12: Every change of dir_tx, and the completion of a checksum, restarts the checksum. A checksum therefore covers only the data bytes sent since the last direction change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| etu_div | input | ETU_W | Clock cycles per bit |
| t1_mode | input | 1 | 1 = T=1 framing, 0 = T=0 |
| chk_en | input | 1 | Append checksum in T=1 |
| crc_sel | input | 1 | 1 = CRC-16, 0 = LRC |
| wr_en | input | 1 | Push wr_data into the queue |
| wr_data | input | 8 | Byte to queue |
| ctl_wr | input | 1 | Control write strobe |
| ctl_dir | input | 1 | Direction written (1 = transmit) |
| ctl_last | input | 1 | Last-byte marker written |
| stat_rd | input | 1 | Status read strobe, clears error flags |
| io_in | input | 1 | Level of the card I/O line |
| io_drv_low | output | 1 | 1 = pull the I/O line low |
| tx_full | output | 1 | Queue full |
| tx_empty | output | 1 | Queue empty / message finished |
| tx_underrun | output | 1 | Underrun flag |
| tx_break | output | 1 | Card error signal seen |
| last_flag | output | 1 | Last-byte marker |
| dir_tx | output | 1 | Current direction, 1 = transmit |
| evt_irq | output | 1 | Transmit event pulse |
| err_irq | output | 1 | Transmit error pulse |

## Verification
A line monitor in the bench decodes every character and compares it with the bytes expected from the writes. That expected sequence already includes retransmissions and checksums, so the character order itself shows whether the break and checksum logic chose its source correctly. The stimulus covers several cases that tell apart specific faults:
- Bytes queued while in receive direction, then released together. This separates direction gating from the full flag.
- A single byte with the marker clear, which isolates underrun.
- One and then two injected card errors, which show a single retry and no second retry.
- An early receive request, which shows the deferred direction change.
- Two T=1 messages split by a direction change, one without and one with a checksum. This reveals whether the checksum restarts.
- A CRC run at a different ETU, which checks byte order and bit timing at once.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;
   // bits driven per character: start, 8 data, parity
   localparam int CHAR_BITS = 10;
   // released line time after the parity bit, in ETU
   localparam int GUARD_ETU = 2;
   localparam int SLOTS     = CHAR_BITS + GUARD_ETU;
   localparam int SLOT_W    = $clog2(SLOTS + 1);
   localparam logic [15:0] CRC_POLY = 16'h1021;
   localparam logic [15:0] CRC_SEED = 16'hFFFF;
endpackage

// File: rtl/sc_tx_fifo.sv
module sc_tx_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("sc_tx_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] rd_p, wr_p;
   logic [AW:0]   cnt;
   logic          do_push, do_pop;

   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign full    = (cnt == (AW+1)'(DEPTH));
   assign empty   = (cnt == '0);
   assign dout    = mem[rd_p];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_p <= '0;
         wr_p <= '0;
         cnt  <= '0;
      end else begin
         if (do_push) wr_p <= wr_p + 1'b1;
         if (do_pop)  rd_p <= rd_p + 1'b1;
         if (do_push && !do_pop)      cnt <= cnt + 1'b1;
         else if (do_pop && !do_push) cnt <= cnt - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_p] <= din;
   end
endmodule

// File: rtl/sc_tx_chk.sv
module sc_tx_chk #(
   parameter bit CRC_EN = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        init,
   input  logic        upd,
   input  logic        crc_sel,
   input  logic [7:0]  din,
   output logic [15:0] sum
);
   import sc_tx_pkg::*;

   logic [7:0] lrc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    lrc_q <= '0;
      else if (init) lrc_q <= '0;
      else if (upd)  lrc_q <= lrc_q ^ din;
   end

   if (CRC_EN) begin : g_crc
      logic [15:0] crc_q;

      function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
         logic [15:0] r;
         logic        fb;
         r = c;
         for (int i = 7; i >= 0; i--) begin
            fb = r[15] ^ d[i];
            r  = {r[14:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
         end
         return r;
      endfunction

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    crc_q <= CRC_SEED;
         else if (init) crc_q <= CRC_SEED;
         else if (upd)  crc_q <= crc_step(crc_q, din);
      end

      assign sum = crc_sel ? crc_q : {8'h00, lrc_q};
   end else begin : g_lrc_only
      assign sum = {8'h00, lrc_q};
   end
endmodule

// File: rtl/sc_tx_ser.sv
module sc_tx_ser #(
   parameter int ETU_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ETU_W-1:0] etu_div,
   input  logic             start,
   input  logic [7:0]       din,
   input  logic             io_in,
   output logic             busy,
   output logic             drv_low,
   output logic             done,
   output logic             brk_hit
);
   import sc_tx_pkg::*;

   logic [ETU_W-1:0]  cnt;
   logic [SLOT_W-1:0] slot;
   logic [9:0]        shreg;
   logic              etu_end;

   assign etu_end = (cnt == etu_div - 1'b1);
   assign done    = busy & etu_end & (slot == SLOT_W'(SLOTS - 1));
   assign drv_low = busy & (slot < SLOT_W'(CHAR_BITS)) & ~shreg[0];
   assign brk_hit = busy & (slot == SLOT_W'(CHAR_BITS)) & (cnt == (etu_div >> 1)) & ~io_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt   <= '0;
         slot  <= '0;
         shreg <= '1;
      end else if (start && !busy) begin
         busy  <= 1'b1;
         cnt   <= '0;
         slot  <= '0;
         shreg <= {^din, din, 1'b0};
      end else if (busy) begin
         if (etu_end) begin
            cnt   <= '0;
            slot  <= slot + 1'b1;
            shreg <= {1'b1, shreg[9:1]};
            if (slot == SLOT_W'(SLOTS - 1)) busy <= 1'b0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/sc_tx_ctrl.sv
module sc_tx_ctrl #(
   parameter int FIFO_DEPTH = 4,
   parameter int ETU_W      = 16,
   parameter bit CRC_EN     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ETU_W-1:0] etu_div,
   input  logic             t1_mode,
   input  logic             chk_en,
   input  logic             crc_sel,
   input  logic             wr_en,
   input  logic [7:0]       wr_data,
   input  logic             ctl_wr,
   input  logic             ctl_dir,
   input  logic             ctl_last,
   input  logic             stat_rd,
   input  logic             io_in,
   output logic             io_drv_low,
   output logic             tx_full,
   output logic             tx_empty,
   output logic             tx_underrun,
   output logic             tx_break,
   output logic             last_flag,
   output logic             dir_tx,
   output logic             evt_irq,
   output logic             err_irq
);
   if (ETU_W < 3) begin : g_bad_etu
      $error("sc_tx_ctrl: ETU_W must be at least 3");
   end

   logic        busy, done, brk_hit;
   logic        fifo_full, fifo_empty;
   logic [7:0]  fifo_q, hold_q, tx_byte, chk_byte;
   logic [15:0] sum;
   logic dir_q, dir_d, pend_q, pend_d, last_q;
   logic undr_q, brk_q, msg_open_q, chk_idx_q;
   logic resend_q, retried_q, cur_brk_q, cur_chk_q;
   logic empty_q, full_q, evt_q, err_q;
   logic chk_pend, can_go, go_resend, go_fifo, go_chk, start;
   logic chk_last, idle_all, empty_flag, dir_chg, sum_init, retry_now, undr_set;

   sc_tx_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(wr_en), .din(wr_data), .pop(go_fifo),
      .dout(fifo_q), .full(fifo_full), .empty(fifo_empty));

   sc_tx_chk #(.CRC_EN(CRC_EN)) u_chk (
      .clk(clk), .rst_n(rst_n), .init(sum_init), .upd(go_fifo),
      .crc_sel(crc_sel), .din(fifo_q), .sum(sum));

   sc_tx_ser #(.ETU_W(ETU_W)) u_ser (
      .clk(clk), .rst_n(rst_n), .etu_div(etu_div), .start(start), .din(tx_byte),
      .io_in(io_in), .busy(busy), .drv_low(io_drv_low), .done(done), .brk_hit(brk_hit));

   // source choice: pending retry first, then queue, then checksum
   assign chk_pend  = t1_mode & chk_en & last_q & msg_open_q & fifo_empty & ~resend_q;
   assign can_go    = dir_q & ~busy;
   assign go_resend = can_go & resend_q;
   assign go_fifo   = can_go & ~resend_q & ~fifo_empty;
   assign go_chk    = can_go & chk_pend;
   assign start     = go_resend | go_fifo | go_chk;
   assign chk_byte  = (crc_sel && !chk_idx_q) ? sum[15:8] : sum[7:0];
   assign tx_byte   = go_resend ? hold_q : (go_fifo ? fifo_q : chk_byte);
   assign chk_last  = ~crc_sel | chk_idx_q;

   assign idle_all   = fifo_empty & ~busy & ~resend_q & ~chk_pend;
   assign empty_flag = fifo_empty & ~(last_q & (busy | resend_q | chk_pend));
   assign retry_now  = done & cur_brk_q & ~t1_mode & ~cur_chk_q & ~retried_q;
   assign undr_set   = done & ~cur_chk_q & ~retry_now & fifo_empty & ~last_q;

   always_comb begin
      dir_d  = dir_q;
      pend_d = pend_q;
      if (ctl_wr) begin
         if (ctl_dir) begin
            dir_d  = 1'b1;
            pend_d = 1'b0;
         end else if (ctl_last && dir_q && !idle_all) begin
            pend_d = 1'b1;
         end else begin
            dir_d  = 1'b0;
            pend_d = 1'b0;
         end
      end else if (pend_q && idle_all) begin
         dir_d  = 1'b0;
         pend_d = 1'b0;
      end
   end

   assign dir_chg  = dir_d ^ dir_q;
   assign sum_init = dir_chg | (done & cur_chk_q & chk_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= 1'b0;      pend_q <= 1'b0;    last_q <= 1'b0;
         undr_q <= 1'b0;     brk_q <= 1'b0;     msg_open_q <= 1'b0;
         chk_idx_q <= 1'b0;  resend_q <= 1'b0;  retried_q <= 1'b0;
         cur_brk_q <= 1'b0;  cur_chk_q <= 1'b0; hold_q <= '0;
         empty_q <= 1'b1;    full_q <= 1'b0;    evt_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         dir_q  <= dir_d;
         pend_q <= pend_d;
         if (ctl_wr) last_q <= ctl_last;
         if (start) begin
            hold_q    <= tx_byte;
            cur_chk_q <= go_chk;
            cur_brk_q <= 1'b0;
         end else if (brk_hit) begin
            cur_brk_q <= 1'b1;
         end
         if (go_resend)      resend_q <= 1'b0;
         else if (retry_now) resend_q <= 1'b1;
         if (done) retried_q <= retry_now;
         if (dir_chg) begin
            msg_open_q <= 1'b0;
            chk_idx_q  <= 1'b0;
         end else if (done && cur_chk_q) begin
            msg_open_q <= msg_open_q & ~chk_last;
            chk_idx_q  <= ~chk_last;
         end else if (go_fifo) begin
            msg_open_q <= 1'b1;
         end
         undr_q  <= undr_set | (undr_q & ~stat_rd);
         brk_q   <= brk_hit | (brk_q & ~stat_rd);
         err_q   <= undr_set | brk_hit;
         empty_q <= empty_flag;
         full_q  <= fifo_full;
         evt_q   <= (empty_flag & ~empty_q) | (fifo_full & ~full_q);
      end
   end

   assign tx_full     = fifo_full;
   assign tx_empty    = empty_flag;
   assign tx_underrun = undr_q;
   assign tx_break    = brk_q;
   assign last_flag   = last_q;
   assign dir_tx      = dir_q;
   assign evt_irq     = evt_q;
   assign err_irq     = err_q;
endmodule

// File: rtl/sc_tx_ctrl_chk.sv
module sc_tx_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic ctl_wr,
   input logic stat_rd,
   input logic tx_full,
   input logic tx_empty,
   input logic tx_underrun,
   input logic tx_break,
   input logic last_flag,
   input logic dir_tx,
   input logic evt_irq,
   input logic err_irq
);
   // R2: the full rise is reported one cycle later
   a_r2_full_evt: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_full) |=> evt_irq);

   // R2 / R5: full and empty never together
   a_r2_full_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_full && tx_empty));

   // R5: empty is held off while the final character is on the line
   a_r5_empty_deferred: assert property (@(posedge clk) disable iff (!rst_n)
      (last_flag && busy) |-> !tx_empty);

   // R6: underrun is sticky until a read
   a_r6_undr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_underrun && !stat_rd) |=> tx_underrun);

   // R7: a read clears the break flag unless a new error arrives
   a_r7_brk_clear: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd |=> (!tx_break || err_irq));

   // R10: transmit direction only comes from a control write
   a_r10_dir_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir_tx && !ctl_wr) |=> !dir_tx);

   // R11: an automatic drop to receive happens only when idle
   a_r11_auto_rx_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_tx && !ctl_wr) |=> (dir_tx || !busy));
endmodule

bind sc_tx_ctrl sc_tx_ctrl_chk u_sc_tx_ctrl_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .ctl_wr(ctl_wr), .stat_rd(stat_rd),
   .tx_full(tx_full), .tx_empty(tx_empty), .tx_underrun(tx_underrun),
   .tx_break(tx_break), .last_flag(last_flag), .dir_tx(dir_tx),
   .evt_irq(evt_irq), .err_irq(err_irq));

// File: tb/sc_tx_ctrl_test.sv
module sc_tx_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] etu_div;
   logic        t1_mode = 1'b0, chk_en = 1'b0, crc_sel = 1'b0;
   logic        wr_en = 1'b0, ctl_wr = 1'b0, ctl_dir = 1'b0, ctl_last = 1'b0, stat_rd = 1'b0;
   logic [7:0]  wr_data = '0;
   logic        io_drv_low, tx_full, tx_empty, tx_underrun, tx_break;
   logic        last_flag, dir_tx, evt_irq, err_irq;
   logic        card_pull = 1'b0;
   logic        line;

   int n_chk = 0, n_err = 0, evt_cnt = 0, err_cnt = 0, brk_left = 0, etu = 8;
   string cur_req = "R3";
   logic [7:0] exp_q[$];
   logic [7:0] msg[$];

   always #2 clk = ~clk;   // 250 MHz

   assign line = ~io_drv_low & ~card_pull;
   assign etu_div = 16'(etu);

   sc_tx_ctrl uut (
      .clk(clk), .rst_n(rst_n), .etu_div(etu_div), .t1_mode(t1_mode), .chk_en(chk_en),
      .crc_sel(crc_sel), .wr_en(wr_en), .wr_data(wr_data), .ctl_wr(ctl_wr),
      .ctl_dir(ctl_dir), .ctl_last(ctl_last), .stat_rd(stat_rd), .io_in(line),
      .io_drv_low(io_drv_low), .tx_full(tx_full), .tx_empty(tx_empty),
      .tx_underrun(tx_underrun), .tx_break(tx_break), .last_flag(last_flag),
      .dir_tx(dir_tx), .evt_irq(evt_irq), .err_irq(err_irq));

   always @(negedge clk) begin
      if (rst_n && evt_irq) evt_cnt++;
      if (rst_n && err_irq) err_cnt++;
   end

   task automatic check(input string req, input int act, input int expv);
      n_chk++;
      if (act != expv) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [7:0] b);
      wr_en = 1'b1; wr_data = b;
      exp_q.push_back(b);
      msg.push_back(b);
      wait_clk(1);
      wr_en = 1'b0;
   endtask

   task automatic ctl(input logic d, input logic l);
      ctl_wr = 1'b1; ctl_dir = d; ctl_last = l;
      wait_clk(1);
      ctl_wr = 1'b0;
   endtask

   task automatic rd();
      stat_rd = 1'b1;
      wait_clk(1);
      stat_rd = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() != 0) wait_clk(1);
      wait_clk(4 * etu);
   endtask

   function automatic logic [7:0] lrc_of(input logic [7:0] d[$]);
      logic [7:0] r = 8'h00;
      foreach (d[i]) r ^= d[i];
      return r;
   endfunction

   function automatic logic [15:0] crc_of(input logic [7:0] d[$]);
      logic [15:0] r = 16'hFFFF;
      foreach (d[i]) begin
         for (int b = 7; b >= 0; b--) begin
            if (r[15] ^ d[i][b]) r = {r[14:0], 1'b0} ^ 16'h1021;
            else                 r = {r[14:0], 1'b0};
         end
      end
      return r;
   endfunction

   // line monitor and card model
   initial begin
      logic [8:0] bits;
      logic       st;
      forever begin
         @(negedge clk);
         if (rst_n && line === 1'b0 && !card_pull) begin
            repeat (etu / 2) @(negedge clk);
            st = line;
            for (int i = 0; i < 9; i++) begin
               repeat (etu) @(negedge clk);
               bits[i] = line;
            end
            check("R3 start bit", int'(st), 0);
            check("R3 even parity", int'(^bits), 0);
            if (exp_q.size() == 0) begin
               check({cur_req, " unexpected char"}, int'(bits[7:0]), -1);
            end else begin
               check({cur_req, " char data"}, int'(bits[7:0]), int'(exp_q.pop_front()));
            end
            if (brk_left > 0) begin
               brk_left--;
               repeat (etu / 2) @(negedge clk);
               card_pull = 1'b1;
               repeat (etu + etu / 2) @(negedge clk);
               card_pull = 1'b0;
            end else begin
               while (line == 1'b0) @(negedge clk);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      report();
   end

   initial begin
      int e0, r0;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(2);
      // R1 reset state
      check("R1 empty", int'(tx_empty), 1);
      check("R1 full", int'(tx_full), 0);
      check("R1 dir", int'(dir_tx), 0);
      check("R1 last", int'(last_flag), 0);
      check("R1 underrun", int'(tx_underrun), 0);
      check("R1 break", int'(tx_break), 0);
      check("R1 line", int'(io_drv_low), 0);

      // R2 / R10: fill while in receive direction
      cur_req = "R4";
      e0 = evt_cnt;
      wr(8'hA5); wr(8'h3C); wr(8'h01);
      check("R2 not full at 3", int'(tx_full), 0);
      wr(8'hFF);
      check("R2 full at 4", int'(tx_full), 1);
      wait_clk(2);
      check("R2 full event", evt_cnt - e0, 1);
      wait_clk(20 * etu);
      check("R10 nothing sent in rx", exp_q.size(), 4);
      check("R10 still full", int'(tx_full), 1);
      // R5: send with marker set
      ctl(1'b1, 1'b1);
      while (exp_q.size() != 1) wait_clk(1);
      wait_clk(4 * etu);
      check("R5 empty held during last char", int'(tx_empty), 0);
      e0 = evt_cnt;
      drain();
      check("R5 empty after last char", int'(tx_empty), 1);
      check("R5 empty event", evt_cnt - e0, 1);
      check("R6 no underrun with marker", int'(tx_underrun), 0);
      msg.delete();

      // R6 underrun
      cur_req = "R6";
      ctl(1'b1, 1'b0);
      r0 = err_cnt;
      wr(8'h5A);
      drain();
      check("R6 underrun set", int'(tx_underrun), 1);
      check("R6 error pulse", err_cnt - r0, 1);
      rd();
      check("R6 cleared by read", int'(tx_underrun), 0);
      msg.delete();

      // R7 break with one retry
      cur_req = "R7";
      ctl(1'b1, 1'b0);
      brk_left = 1;
      r0 = err_cnt;
      wr(8'h81); wr(8'h42);
      exp_q.delete(); exp_q.push_back(8'h81); exp_q.push_back(8'h81); exp_q.push_back(8'h42);
      ctl(1'b1, 1'b1);
      drain();
      check("R7 break flag", int'(tx_break), 1);
      check("R7 one error pulse", err_cnt - r0, 1);
      rd();
      check("R7 cleared by read", int'(tx_break), 0);
      // two errors in a row: still only one retry
      ctl(1'b1, 1'b0);
      brk_left = 2;
      r0 = err_cnt;
      wr(8'h7E); wr(8'h18);
      exp_q.delete(); exp_q.push_back(8'h7E); exp_q.push_back(8'h7E); exp_q.push_back(8'h18);
      ctl(1'b1, 1'b1);
      drain();
      check("R7 two error pulses", err_cnt - r0, 2);
      check("R7 no underrun", int'(tx_underrun), 0);
      rd();
      msg.delete();

      // R11 deferred receive
      cur_req = "R11";
      ctl(1'b1, 1'b0);
      wr(8'h11); wr(8'h22);
      ctl(1'b0, 1'b1);
      wait_clk(2);
      check("R11 dir held", int'(dir_tx), 1);
      drain();
      check("R11 dir dropped", int'(dir_tx), 0);
      // R10 immediate receive
      ctl(1'b1, 1'b0);
      check("R10 dir set", int'(dir_tx), 1);
      ctl(1'b0, 1'b0);
      check("R10 dir cleared", int'(dir_tx), 0);
      msg.delete();

      // R8 LRC
      cur_req = "R8";
      t1_mode = 1'b1; chk_en = 1'b1; crc_sel = 1'b0;
      ctl(1'b1, 1'b0);
      wr(8'h12); wr(8'h34); wr(8'h56);
      exp_q.push_back(lrc_of(msg));
      ctl(1'b1, 1'b1);
      while (exp_q.size() != 1) wait_clk(1);
      wait_clk(4 * etu);
      check("R8 empty held during LRC", int'(tx_empty), 0);
      drain();
      check("R8 empty after LRC", int'(tx_empty), 1);

      // R12 checksum restarts on direction change
      cur_req = "R12";
      ctl(1'b0, 1'b0);
      chk_en = 1'b0;
      ctl(1'b1, 1'b0);
      wr(8'hAA); wr(8'h0F);
      ctl(1'b1, 1'b1);
      drain();
      ctl(1'b0, 1'b0);
      chk_en = 1'b1;
      msg.delete();
      ctl(1'b1, 1'b0);
      wr(8'h33); wr(8'h44);
      exp_q.push_back(lrc_of(msg));
      ctl(1'b1, 1'b1);
      drain();

      // R9 CRC at a different bit time (R4)
      cur_req = "R9 R4";
      ctl(1'b0, 1'b0);
      etu = 12;
      crc_sel = 1'b1;
      msg.delete();
      ctl(1'b1, 1'b0);
      wr(8'h31); wr(8'h32); wr(8'h33);
      begin
         logic [15:0] c;
         c = crc_of(msg);
         exp_q.push_back(c[15:8]);
         exp_q.push_back(c[7:0]);
      end
      ctl(1'b1, 1'b1);
      drain();
      check("R9 all chars seen", exp_q.size(), 0);
      check("R9 empty at end", int'(tx_empty), 1);
      report();
   end
endmodule